// File: doc/BRIEF.md
# Free Buffer Threshold Pulse Interrupt

This block watches a set of receive DMA channels and raises an immediate interrupt when any enabled channel runs short of free buffers. Each channel keeps a saturating free buffer counter, moved up and down by one-cycle strobes from the buffer manager. Each channel also has a host-programmed threshold. A channel's condition holds whenever its count is at or below its threshold.

Two independent enable layers sit between a channel's condition and the single interrupt line. The first is a channel mask, changed through separate set and clear writes. The second is a routing register that selects which channels may drive the line. Raw, masked and routed status stay readable whatever the routing register holds, so software can poll instead of taking interrupts.

The interrupt is a one-cycle pulse. It fires when the OR of the routed conditions goes from low to high. It fires again when the host writes the end-of-interrupt code while a routed condition is still true. No pacing or coalescing delay is applied.

Top module: `buf_thresh_irq`

## Requirements
- R1: After reset the interrupt output is 0. The mask, routing register, all thresholds and all free buffer counts read 0. Raw status therefore reads all ones, and masked and routed status read 0.
- R2: A channel's free buffer count (read at word address 32+ch) rises by one on an increment strobe and falls by one on a decrement strobe. It holds when both strobes or neither are high. It saturates at 0 and at 2^CNT_W-1 without wrapping.
- R3: Writing address 0 sets every mask bit whose data bit is 1, and writing address 1 clears every mask bit whose data bit is 1. Data bits of 0 leave mask bits unchanged. Both addresses read back the mask in bits [NUM_CH-1:0].
- R4: Each channel's threshold is a read/write register at word address 16+ch, holding data bits [CNT_W-1:0]. Raw status (address 3, bit ch) is 1 exactly when the channel's count is less than or equal to its threshold.
- R5: Masked status (address 4) equals raw & mask. The routing register is read/write at address 2. Routed status (address 6) equals raw & mask & routing.
- R6: The interrupt output is high for exactly one cycle, in the cycle after the first cycle in which the OR of routed status is 1. A change to a count, threshold, mask or routing bit takes effect on routed status in the cycle after its strobe or write is presented.
- R7: Presenting a write of value 0 to address 5 drives the interrupt high in the following cycle if the routed OR is 1 in the write cycle. A write of any nonzero value to address 5 has no effect, and so does a value-0 write while the routed OR is 0.
- R8: With the routing register cleared to 0, the interrupt never fires, while raw and masked status keep reporting the channel conditions.
- R9: While the routed OR stays at 1 with no end-of-interrupt write, no further pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| buf_inc | input | NUM_CH | Per-channel free buffer increment strobes |
| buf_dec | input | NUM_CH | Per-channel free buffer decrement strobes |
| thresh_irq | output | 1 | One-cycle threshold interrupt pulse |

## Verification
The comparator is swept over every pair of threshold and count for a 4-bit counter. This separates the at-or-below relation from strict below and from an off-by-one bound. The counter is driven past both ends, and with both strobes high, to show saturation apart from wraparound. Pulses are triggered in turn by a routing write, a threshold write, a count decrement, a mask set and end-of-interrupt writes of zero and nonzero value. This shows that each path reaches the output edge detector and that a sustained condition does not re-fire. Routing is then cleared while status is read, to show that the two enable layers act apart.

// File: rtl/buf_thresh_pkg.sv
package buf_thresh_pkg;
   // register word addresses
   localparam int A_MASK_SET = 0;
   localparam int A_MASK_CLR = 1;
   localparam int A_ROUTE    = 2;
   localparam int A_RAW      = 3;
   localparam int A_MASKED   = 4;
   localparam int A_EOI      = 5;
   localparam int A_ROUTED   = 6;
   localparam int A_THR_BASE = 16;
   localparam int A_CNT_BASE = 32;
   // value that re-arms the pulse when written to A_EOI
   localparam int EOI_CODE   = 0;

   typedef struct packed {
      logic mask_set;
      logic mask_clr;
      logic route;
      logic eoi;
   } wr_dec_t;
endpackage

// File: rtl/bt_chan_cnt.sv
module bt_chan_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic [CNT_W-1:0] thresh,
   output logic [CNT_W-1:0] count,
   output logic             cond
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;
   assign cond  = (cnt_q <= thresh);

   // R2: no wrap past the top
   p_sat_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX));
   // R2: no wrap below zero
   p_sat_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));
   // R2: opposing strobes cancel
   p_hold_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(cnt_q));
endmodule

// File: rtl/bt_regs.sv
module bt_regs
   import buf_thresh_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NUM_CH-1:0]            raw,
   input  logic [NUM_CH-1:0]            masked,
   input  logic [NUM_CH-1:0]            routed,
   input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
   output logic [NUM_CH-1:0]            mask,
   output logic [NUM_CH-1:0]            route,
   output logic [NUM_CH-1:0][CNT_W-1:0] thresh,
   output logic                         eoi,
   output logic [DATA_W-1:0]            rdata
);
   wr_dec_t                     dec;
   logic [NUM_CH-1:0]           mask_q;
   logic [NUM_CH-1:0]           route_q;
   logic [NUM_CH-1:0][CNT_W-1:0] thr_q;
   logic [NUM_CH-1:0]           wbits;

   assign wbits = wdata[NUM_CH-1:0];

   always_comb begin
      dec.mask_set = wr && (addr == ADDR_W'(A_MASK_SET));
      dec.mask_clr = wr && (addr == ADDR_W'(A_MASK_CLR));
      dec.route    = wr && (addr == ADDR_W'(A_ROUTE));
      dec.eoi      = wr && (addr == ADDR_W'(A_EOI)) && (wdata == DATA_W'(EOI_CODE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         route_q <= '0;
      end else begin
         if (dec.mask_set) mask_q <= mask_q | wbits;
         else if (dec.mask_clr) mask_q <= mask_q & ~wbits;
         if (dec.route) route_q <= wbits;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= '0;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (wr && (addr == ADDR_W'(A_THR_BASE + i))) thr_q[i] <= wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_MASK_SET) || addr == ADDR_W'(A_MASK_CLR)) rdata[NUM_CH-1:0] = mask_q;
      if (addr == ADDR_W'(A_ROUTE))  rdata[NUM_CH-1:0] = route_q;
      if (addr == ADDR_W'(A_RAW))    rdata[NUM_CH-1:0] = raw;
      if (addr == ADDR_W'(A_MASKED)) rdata[NUM_CH-1:0] = masked;
      if (addr == ADDR_W'(A_ROUTED)) rdata[NUM_CH-1:0] = routed;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(A_THR_BASE + i)) rdata[CNT_W-1:0] = thr_q[i];
         if (addr == ADDR_W'(A_CNT_BASE + i)) rdata[CNT_W-1:0] = counts[i];
      end
   end

   assign mask   = mask_q;
   assign route  = route_q;
   assign thresh = thr_q;
   assign eoi    = dec.eoi;

   // R3: bits written to the set address end up set
   p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec.mask_set |=> ((mask_q & $past(wbits)) == $past(wbits)));
   // R3: bits written to the clear address end up clear
   p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec.mask_clr |=> ((mask_q & $past(wbits)) == '0));
endmodule

// File: rtl/bt_pulse.sv
module bt_pulse #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] routed,
   input  logic              eoi,
   output logic              irq
);
   logic any_act;
   logic any_prev_q;
   logic irq_q;

   assign any_act = |routed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         any_prev_q <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         any_prev_q <= any_act;
         irq_q      <= (any_act && !any_prev_q) || (eoi && any_act);
      end
   end

   assign irq = irq_q;

   // R6: a new routed condition yields a pulse next cycle
   p_rise_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_act) |=> irq_q);
   // R7: end-of-interrupt while active re-fires
   p_eoi_refire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && any_act) |=> irq_q);
   // R9: a sustained condition without EOI stays quiet
   p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_act && $past(any_act) && !eoi) |=> !irq_q);
   // R8: a pulse always has an active routed condition behind it
   p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(any_act));
endmodule

// File: rtl/buf_thresh_irq.sv
module buf_thresh_irq #(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] buf_inc,
   input  logic [NUM_CH-1:0] buf_dec,
   output logic              thresh_irq
);
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must lie in 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (DATA_W < NUM_CH || DATA_W < CNT_W) begin : g_bad_data
      $error("DATA_W must cover NUM_CH and CNT_W");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [NUM_CH-1:0]            raw;
   logic [NUM_CH-1:0]            masked;
   logic [NUM_CH-1:0]            routed;
   logic [NUM_CH-1:0]            mask;
   logic [NUM_CH-1:0]            route;
   logic [NUM_CH-1:0][CNT_W-1:0] thresh;
   logic [NUM_CH-1:0][CNT_W-1:0] counts;
   logic                         eoi;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      bt_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (buf_inc[c]),
         .dec    (buf_dec[c]),
         .thresh (thresh[c]),
         .count  (counts[c]),
         .cond   (raw[c])
      );
   end

   assign masked = raw & mask;
   assign routed = masked & route;

   bt_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr_en),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .raw    (raw),
      .masked (masked),
      .routed (routed),
      .counts (counts),
      .mask   (mask),
      .route  (route),
      .thresh (thresh),
      .eoi    (eoi),
      .rdata  (reg_rdata)
   );

   bt_pulse #(.NUM_CH(NUM_CH)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .routed (routed),
      .eoi    (eoi),
      .irq    (thresh_irq)
   );
endmodule

// File: tb/tb_buf_thresh_irq.sv
module tb_buf_thresh_irq;
   localparam int NCH = 8;
   localparam int CW  = 4;
   localparam int AW  = 6;
   localparam int DW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NCH-1:0] buf_inc = '0;
   logic [NCH-1:0] buf_dec = '0;
   logic          thresh_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   buf_thresh_irq #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_inc(buf_inc),
      .buf_dec(buf_dec), .thresh_irq(thresh_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic rdchk(input string tag, input int a, input int exp);
      int v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic strobe(input int ch, input bit up, input bit down, input int n);
      if (n > 0) begin
         @(negedge clk);
         buf_inc[ch] = up; buf_dec[ch] = down;
         repeat (n) @(negedge clk);
         buf_inc = '0; buf_dec = '0;
      end
   endtask

   // after a write/strobe: quiet now, high for one cycle next, then low
   task automatic expect_rise(input string tag);
      chk(tag, int'(thresh_irq), 0);
      @(negedge clk); chk(tag, int'(thresh_irq), 1);
      @(negedge clk); chk(tag, int'(thresh_irq), 0);
   endtask

   task automatic expect_none(input string tag);
      for (int k = 0; k < 4; k++) begin
         chk(tag, int'(thresh_irq), 0);
         @(negedge clk);
      end
   endtask

   // after an EOI write: high now, low next
   task automatic expect_eoi(input string tag);
      chk(tag, int'(thresh_irq), 1);
      @(negedge clk); chk(tag, int'(thresh_irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", int'(thresh_irq), 0);
      rdchk("R1 mask", 0, 0);
      rdchk("R1 route", 2, 0);
      rdchk("R1 raw", 3, 8'hFF);
      rdchk("R1 masked", 4, 0);
      rdchk("R1 routed", 6, 0);
      for (int c = 0; c < NCH; c++) begin
         rdchk("R1 thresh", 16 + c, 0);
         rdchk("R1 count", 32 + c, 0);
      end

      // R2 counter stepping and saturation on channel 0
      for (int n = 1; n <= 18; n++) begin
         strobe(0, 1'b1, 1'b0, 1);
         rdchk("R2 inc", 32, (n > 15) ? 15 : n);
      end
      strobe(0, 1'b1, 1'b1, 3);
      rdchk("R2 both hold", 32, 15);
      for (int n = 1; n <= 18; n++) begin
         strobe(0, 1'b0, 1'b1, 1);
         rdchk("R2 dec", 32, (15 - n < 0) ? 0 : 15 - n);
      end
      strobe(0, 1'b1, 1'b1, 2);
      rdchk("R2 both hold at 0", 32, 0);
      strobe(3, 1'b1, 1'b0, 7);
      rdchk("R2 other channel", 35, 7);
      strobe(3, 1'b0, 1'b1, 7);
      rdchk("R2 other channel back", 35, 0);

      // R4 exhaustive threshold x count sweep on channel 0
      for (int t = 0; t < 16; t++) begin
         wr(16, t);
         rdchk("R4 thresh readback", 16, t);
         strobe(0, 1'b0, 1'b1, 16);
         for (int v = 0; v < 16; v++) begin
            rdchk("R4 raw compare", 3, 8'hFE | ((v <= t) ? 1 : 0));
            strobe(0, 1'b1, 1'b0, 1);
         end
      end
      // ch0 now count 15, thresh 15

      // R3 mask set / clear
      wr(0, 8'hA5);
      rdchk("R3 set", 0, 8'hA5);
      wr(0, 8'h0F);
      rdchk("R3 set accumulates", 1, 8'hAF);
      wr(1, 8'h81);
      rdchk("R3 clear", 0, 8'h2E);
      wr(1, 8'h00);
      rdchk("R3 clear zero no effect", 1, 8'h2E);

      // R5 status layers: ch1 count 5 above thresh 0
      strobe(1, 1'b1, 1'b0, 5);
      rdchk("R5 raw", 3, 8'hFD);
      rdchk("R5 masked", 4, 8'h2C);
      expect_none("R8 routing off");
      wr(2, 8'h0C);
      expect_rise("R6 routing write");
      rdchk("R5 route readback", 2, 8'h0C);
      rdchk("R5 routed", 6, 8'h0C);
      expect_none("R9 sustained");
      wr(2, 8'h02);
      expect_none("R6 routed falls");
      rdchk("R5 routed empty", 6, 0);

      // R6 threshold write brings ch1 into condition
      wr(17, 5);
      expect_rise("R6 threshold write");
      rdchk("R5 routed ch1", 6, 8'h02);
      expect_none("R9 sustained ch1");

      // R7 end of interrupt
      wr(5, 0);
      expect_eoi("R7 eoi zero refires");
      wr(5, 3);
      expect_none("R7 eoi nonzero ignored");
      strobe(1, 1'b1, 1'b0, 1);
      rdchk("R6 count above thresh", 6, 0);
      wr(5, 0);
      expect_none("R7 eoi while idle");
      strobe(1, 1'b0, 1'b1, 1);
      expect_rise("R6 count decrement");

      // R8 routing cleared, status still pollable
      wr(2, 0);
      expect_none("R8 route cleared");
      rdchk("R8 raw pollable", 3, 8'hFF);
      rdchk("R8 masked pollable", 4, 8'h2E);
      rdchk("R8 routed empty", 6, 0);
      wr(5, 0);
      expect_none("R8 eoi with routing off");
      wr(2, 8'h02);
      expect_rise("R6 routing restored");

      // R3/R6 mask layer gating
      wr(1, 8'h02);
      expect_none("R3 mask cleared");
      wr(0, 8'h02);
      expect_rise("R3 mask set fires");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule